// File: doc/BRIEF.md
# Virtual Disk Sector Translator

This block lets one flash card hold several host disks. The host asks for 256-byte logical blocks. The card stores 512-byte sectors. A rotary BCD switch picks a virtual disk. The block turns the switch value and the host block address into a card sector address and a half-sector select. Two virtual disks share each card sector, one in each half. Every even switch value and the odd value just above it form a pair. Each pair owns its own region of 2^21 card sectors.

The switch is read once, in the first clock after reset, and that value is kept. A one-bit capacity code says how many regions the fitted card holds, and the block flags switch values that do not fit. An illegal request ends at once with an error flag and starts no card access.

A read fetches the whole card sector from a downstream sector engine into a 512-byte buffer, then streams only the selected half to the host. A write also fetches the whole sector first. It then takes 256 host bytes into the selected half and hands all 512 bytes back to the engine. The neighbouring half is therefore preserved.

Top module: `vdt_top`

## Requirements
- R1: The switch value is captured in the first clock after reset is released and is held until the next reset. Later changes on `sel_sw` have no effect on the mapping.
- R2: Only switch bits 2..0 are used. Bit 3 has no effect, so a switch value v with bit 3 set maps exactly like v with bit 3 clear.
- R3: For a legal request, `card_lba` = (sel >> 1) * 2^21 + `host_lba`, and `half_sel` = sel bit 0, where 0 is bytes 0..255 of the sector and 1 is bytes 256..511.
- R4: `legal` is 1 when (sel >> 1) < 2^(`cap_code`+1). With `cap_code`=0 (2 GB card) sel 0..3 are legal. With `cap_code`=1 (4 GB card) sel 0..7 are legal.
- R5: An illegal request is rejected. In the cycle after it is accepted, `done` and `chk_err` are both 1 and `busy` stays 0, and `eng_req` is never raised for that request.
- R6: A read raises `eng_req` with `eng_wr`=0 and stores the bytes of each `eng_rvalid` cycle in sector order. After `eng_done` it gives 256 consecutive `host_rvalid` cycles, and byte k is sector byte `half_sel`*256+k.
- R7: A write first reads the sector as in R6. It then accepts 256 host bytes on cycles with `host_wvalid` and `host_wready` both 1. Last it raises `eng_req` with `eng_wr`=1 and presents 512 bytes on `eng_wdata`, advancing on each `eng_wready` cycle. The selected half holds the host bytes and the other half holds the bytes that were read.
- R8: `busy` is 1 from the cycle after a legal request is accepted until the final transfer ends. `done` is a one-cycle pulse in the cycle `busy` falls, and `chk_err` is only ever 1 together with `done`.
- R9: A `req` seen while `busy` is 1 is ignored. `card_lba` stays unchanged and no new transfer starts after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_sw | input | 4 | BCD virtual disk switch; bit 3 unused |
| cap_code | input | 1 | Card capacity: 0 = 2 GB, 1 = 4 GB |
| req | input | 1 | Host request, sampled when idle |
| is_write | input | 1 | 1 = write, 0 = read |
| host_lba | input | 21 | Host 256-byte block address |
| card_lba | output | 23 | Card sector address of the current request |
| half_sel | output | 1 | Sector half used by the current request |
| legal | output | 1 | Held selector fits the card capacity |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| chk_err | output | 1 | Check-condition error, with done |
| eng_req | output | 1 | Sector engine request (held until eng_done) |
| eng_wr | output | 1 | Engine direction: 1 = write sector |
| eng_done | input | 1 | Engine finished the sector transfer |
| eng_rvalid | input | 1 | Engine read byte valid |
| eng_rdata | input | 8 | Engine read byte |
| eng_wready | input | 1 | Engine takes eng_wdata this cycle |
| eng_wdata | output | 8 | Byte to be written to the card |
| host_wvalid | input | 1 | Host write byte valid |
| host_wdata | input | 8 | Host write byte |
| host_wready | output | 1 | Block accepts host write bytes |
| host_rvalid | output | 1 | Host read byte valid |
| host_rdata | output | 8 | Host read byte |

## Verification
Some properties are checked on every cycle. These are the handshake timing rules: done lasts one cycle and coincides with busy falling, an error only comes with done, and an illegal request never reaches the engine or sets busy. They also cover the held selector and the stable card address during a transfer, and host read bytes appearing only while busy. Only the bench scenarios can show the data path. That covers the region-and-half address arithmetic, the byte order of the returned half, and whether the untouched half survives the read-modify-write. It also covers the effect of switch changes after reset and of the unwired bit 3.

// File: rtl/vdt_pkg.sv
package vdt_pkg;

    localparam int VD_BYTE_W     = 8;
    localparam int VD_SECT_BYTES = 512;
    localparam int VD_HLBA_W     = 21;
    localparam int VD_SEL_W      = 3;
    localparam int VD_SW_W       = 4;
    localparam int VD_CAP_W      = 1;
    localparam int VD_MIN_REG_L2 = 1;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CRD  = 3'd1,
        ST_HIN  = 3'd2,
        ST_HOUT = 3'd3,
        ST_CWR  = 3'd4
    } vd_state_t;

    function automatic logic region_fits(input int unsigned region,
                                         input int unsigned cap,
                                         input int unsigned min_l2);
        return region < (32'd1 << (cap + min_l2));
    endfunction

endpackage

// File: rtl/vdt_sel_latch.sv
module vdt_sel_latch #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_in,
    output logic [SEL_W-1:0] sel_q,
    output logic             sel_vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            sel_vld <= 1'b0;
        end else if (!sel_vld) begin
            sel_q   <= sel_in;
            sel_vld <= 1'b1;
        end
    end
endmodule

// File: rtl/vdt_map.sv
module vdt_map
    import vdt_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int HLBA_W = 21,
    parameter int CAP_W  = 1,
    parameter int MIN_L2 = 1,
    localparam int REG_W  = SEL_W - 1,
    localparam int CLBA_W = REG_W + HLBA_W
) (
    input  logic [SEL_W-1:0]  sel_q,
    input  logic              sel_vld,
    input  logic [CAP_W-1:0]  cap_code,
    input  logic [HLBA_W-1:0] host_lba,
    output logic [CLBA_W-1:0] map_lba,
    output logic              map_half,
    output logic              map_legal
);
    logic [REG_W-1:0] region;

    assign region    = sel_q[SEL_W-1:1];
    assign map_lba   = {region, host_lba};
    assign map_half  = sel_q[0];
    assign map_legal = sel_vld &&
                       region_fits(32'(region), 32'(cap_code), 32'(MIN_L2));
endmodule

// File: rtl/vdt_buf.sv
module vdt_buf #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/vdt_ctrl.sv
module vdt_ctrl
    import vdt_pkg::*;
#(
    parameter int CLBA_W = 23,
    parameter int SECT   = 512,
    parameter int DW     = 8,
    localparam int PTR_W  = $clog2(SECT),
    localparam int HPTR_W = PTR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_vld,
    input  logic              req,
    input  logic              is_write,
    input  logic [CLBA_W-1:0] map_lba,
    input  logic              map_half,
    input  logic              map_legal,
    input  logic              eng_done,
    input  logic              eng_rvalid,
    input  logic [DW-1:0]     eng_rdata,
    input  logic              eng_wready,
    input  logic              host_wvalid,
    input  logic [DW-1:0]     host_wdata,
    output logic              busy,
    output logic              done,
    output logic              chk_err,
    output logic              eng_req,
    output logic              eng_wr,
    output logic [CLBA_W-1:0] card_lba,
    output logic              half_sel,
    output logic              host_wready,
    output logic              host_rvalid,
    output logic              buf_we,
    output logic [PTR_W-1:0]  buf_waddr,
    output logic [DW-1:0]     buf_wdata,
    output logic [PTR_W-1:0]  buf_raddr
);
    vd_state_t         st;
    logic [PTR_W-1:0]  ptr;
    logic              wr_q;
    logic              last_half;
    logic [PTR_W-1:0]  half_addr;

    assign last_half = (ptr[HPTR_W-1:0] == {HPTR_W{1'b1}});
    assign half_addr = {half_sel, ptr[HPTR_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ptr      <= '0;
            wr_q     <= 1'b0;
            card_lba <= '0;
            half_sel <= 1'b0;
            done     <= 1'b0;
            chk_err  <= 1'b0;
        end else begin
            done    <= 1'b0;
            chk_err <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req && sel_vld) begin
                        card_lba <= map_lba;
                        half_sel <= map_half;
                        wr_q     <= is_write;
                        ptr      <= '0;
                        if (map_legal) begin
                            st <= ST_CRD;
                        end else begin
                            done    <= 1'b1;
                            chk_err <= 1'b1;
                        end
                    end
                end
                ST_CRD: begin
                    if (eng_rvalid) ptr <= ptr + 1'b1;
                    if (eng_done) begin
                        ptr <= '0;
                        st  <= wr_q ? ST_HIN : ST_HOUT;
                    end
                end
                ST_HIN: begin
                    if (host_wvalid) begin
                        if (last_half) begin
                            ptr <= '0;
                            st  <= ST_CWR;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                ST_HOUT: begin
                    if (last_half) begin
                        ptr  <= '0;
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else begin
                        ptr <= ptr + 1'b1;
                    end
                end
                ST_CWR: begin
                    if (eng_wready) ptr <= ptr + 1'b1;
                    if (eng_done) begin
                        ptr  <= '0;
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy        = (st != ST_IDLE);
        eng_req     = (st == ST_CRD) || (st == ST_CWR);
        eng_wr      = (st == ST_CWR);
        host_wready = (st == ST_HIN);
        host_rvalid = (st == ST_HOUT);
        buf_we      = ((st == ST_CRD) && eng_rvalid) ||
                      ((st == ST_HIN) && host_wvalid);
        buf_waddr   = (st == ST_CRD) ? ptr : half_addr;
        buf_wdata   = (st == ST_CRD) ? eng_rdata : host_wdata;
        buf_raddr   = (st == ST_HOUT) ? half_addr : ptr;
    end
endmodule

// File: rtl/vdt_top.sv
module vdt_top
    import vdt_pkg::*;
#(
    parameter int HLBA_W = VD_HLBA_W,
    parameter int SEL_W  = VD_SEL_W,
    parameter int SW_W   = VD_SW_W,
    parameter int CAP_W  = VD_CAP_W,
    parameter int MIN_L2 = VD_MIN_REG_L2,
    parameter int SECT   = VD_SECT_BYTES,
    parameter int DW     = VD_BYTE_W,
    localparam int CLBA_W = SEL_W - 1 + HLBA_W,
    localparam int PTR_W  = $clog2(SECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SW_W-1:0]   sel_sw,
    input  logic [CAP_W-1:0]  cap_code,
    input  logic              req,
    input  logic              is_write,
    input  logic [HLBA_W-1:0] host_lba,
    output logic [CLBA_W-1:0] card_lba,
    output logic              half_sel,
    output logic              legal,
    output logic              busy,
    output logic              done,
    output logic              chk_err,
    output logic              eng_req,
    output logic              eng_wr,
    input  logic              eng_done,
    input  logic              eng_rvalid,
    input  logic [DW-1:0]     eng_rdata,
    input  logic              eng_wready,
    output logic [DW-1:0]     eng_wdata,
    input  logic              host_wvalid,
    input  logic [DW-1:0]     host_wdata,
    output logic              host_wready,
    output logic              host_rvalid,
    output logic [DW-1:0]     host_rdata
);
    logic [SEL_W-1:0]  sel_q;
    logic              sel_vld;
    logic [CLBA_W-1:0] map_lba;
    logic              map_half;
    logic              buf_we;
    logic [PTR_W-1:0]  buf_waddr;
    logic [PTR_W-1:0]  buf_raddr;
    logic [DW-1:0]     buf_wdata;
    logic [DW-1:0]     buf_rdata;
    logic              sw_unused;

    generate
        if (SW_W > SEL_W) begin : g_sw_hi
            assign sw_unused = ^sel_sw[SW_W-1:SEL_W];
        end else begin : g_sw_fit
            assign sw_unused = 1'b0;
        end
    endgenerate

    vdt_sel_latch #(.SEL_W(SEL_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .sel_in  (sel_sw[SEL_W-1:0]),
        .sel_q   (sel_q),
        .sel_vld (sel_vld)
    );

    vdt_map #(
        .SEL_W (SEL_W),
        .HLBA_W(HLBA_W),
        .CAP_W (CAP_W),
        .MIN_L2(MIN_L2)
    ) u_map (
        .sel_q    (sel_q),
        .sel_vld  (sel_vld),
        .cap_code (cap_code),
        .host_lba (host_lba),
        .map_lba  (map_lba),
        .map_half (map_half),
        .map_legal(legal)
    );

    vdt_ctrl #(
        .CLBA_W(CLBA_W),
        .SECT  (SECT),
        .DW    (DW)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sel_vld    (sel_vld),
        .req        (req),
        .is_write   (is_write),
        .map_lba    (map_lba),
        .map_half   (map_half),
        .map_legal  (legal),
        .eng_done   (eng_done),
        .eng_rvalid (eng_rvalid),
        .eng_rdata  (eng_rdata),
        .eng_wready (eng_wready),
        .host_wvalid(host_wvalid),
        .host_wdata (host_wdata),
        .busy       (busy),
        .done       (done),
        .chk_err    (chk_err),
        .eng_req    (eng_req),
        .eng_wr     (eng_wr),
        .card_lba   (card_lba),
        .half_sel   (half_sel),
        .host_wready(host_wready),
        .host_rvalid(host_rvalid),
        .buf_we     (buf_we),
        .buf_waddr  (buf_waddr),
        .buf_wdata  (buf_wdata),
        .buf_raddr  (buf_raddr)
    );

    vdt_buf #(.DEPTH(SECT), .DW(DW)) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .waddr(buf_waddr),
        .wdata(buf_wdata),
        .raddr(buf_raddr),
        .rdata(buf_rdata)
    );

    assign eng_wdata  = buf_rdata;
    assign host_rdata = buf_rdata;
endmodule

// File: rtl/vdt_chk.sv
module vdt_chk #(
    parameter int SEL_W  = 3,
    parameter int CLBA_W = 23
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              legal,
    input logic              busy,
    input logic              done,
    input logic              chk_err,
    input logic              eng_req,
    input logic              host_rvalid,
    input logic [CLBA_W-1:0] card_lba,
    input logic [SEL_W-1:0]  sel_q,
    input logic              sel_vld
);
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_at_busy_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r5_err_with_done: assert property (@(posedge clk) disable iff (rst)
        chk_err |-> done);

    a_r5_illegal_no_access: assert property (@(posedge clk) disable iff (rst)
        (req && !busy && !legal) |=> (!busy && !eng_req));

    a_r1_sel_held: assert property (@(posedge clk) disable iff (rst)
        (sel_vld && $past(sel_vld)) |-> $stable(sel_q));

    a_r9_lba_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(card_lba));

    a_r6_rvalid_in_busy: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> (busy && !eng_req));
endmodule

bind vdt_top vdt_chk #(.SEL_W(SEL_W), .CLBA_W(CLBA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .legal      (legal),
    .busy       (busy),
    .done       (done),
    .chk_err    (chk_err),
    .eng_req    (eng_req),
    .host_rvalid(host_rvalid),
    .card_lba   (card_lba),
    .sel_q      (sel_q),
    .sel_vld    (sel_vld)
);

// File: tb/vdt_top_tb.sv
module vdt_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  sel_sw = '0;
    logic [0:0]  cap_code = '0;
    logic        req = 1'b0;
    logic        is_write = 1'b0;
    logic [20:0] host_lba = '0;
    logic [22:0] card_lba;
    logic        half_sel, legal, busy, done, chk_err, eng_req, eng_wr;
    logic        eng_done = 1'b0;
    logic        eng_rvalid = 1'b0;
    logic [7:0]  eng_rdata = '0;
    logic        eng_wready = 1'b0;
    logic [7:0]  eng_wdata;
    logic        host_wvalid = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        host_wready, host_rvalid;
    logic [7:0]  host_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vdt_top u_dut (
        .clk(clk), .rst(rst), .sel_sw(sel_sw), .cap_code(cap_code),
        .req(req), .is_write(is_write), .host_lba(host_lba),
        .card_lba(card_lba), .half_sel(half_sel), .legal(legal),
        .busy(busy), .done(done), .chk_err(chk_err),
        .eng_req(eng_req), .eng_wr(eng_wr), .eng_done(eng_done),
        .eng_rvalid(eng_rvalid), .eng_rdata(eng_rdata),
        .eng_wready(eng_wready), .eng_wdata(eng_wdata),
        .host_wvalid(host_wvalid), .host_wdata(host_wdata),
        .host_wready(host_wready), .host_rvalid(host_rvalid),
        .host_rdata(host_rdata)
    );

    task automatic check(input string rq, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int clba, input int i);
        return 8'((clba * 7) ^ (i * 13) ^ ((i >> 8) * 8'h5A) ^ (clba >> 9));
    endfunction

    function automatic int exp_lba(input int sel, input int lba);
        return ((sel >> 1) << 21) + lba;
    endfunction

    function automatic bit exp_legal(input int sel, input int cap);
        return (sel >> 1) < (1 << (cap + 1));
    endfunction

    task automatic do_reset(input logic [3:0] sw, input logic [3:0] sw_after);
        @(negedge clk);
        rst = 1'b1;
        sel_sw = sw;
        repeat (3) @(negedge clk);
        check("R8", "reset busy", busy, 0);
        check("R8", "reset done", done, 0);
        check("R6", "reset eng_req", eng_req, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        sel_sw = sw_after;
        @(negedge clk);
    endtask

    task automatic run_txn(input bit wr, input int lba, input int sel,
                           input int cap, input bit poke);
        int clba = exp_lba(sel, lba);
        int half = sel & 1;
        int bad;
        logic [7:0] hd [256];
        logic [7:0] got [512];
        cap_code = 1'(cap);
        #1;
        check("R4", "legal output", legal, exp_legal(sel, cap));
        req = 1'b1; is_write = wr; host_lba = 21'(lba);
        @(negedge clk);
        req = 1'b0;
        if (!exp_legal(sel, cap)) begin
            check("R5", "illegal done", done, 1);
            check("R5", "illegal chk_err", chk_err, 1);
            check("R5", "illegal busy", busy, 0);
            check("R5", "illegal eng_req", eng_req, 0);
            @(negedge clk);
            check("R8", "done one cycle", done, 0);
            check("R5", "no access later", eng_req, 0);
            return;
        end
        check("R8", "busy after accept", busy, 1);
        check("R3", "card_lba", card_lba, clba);
        check("R3", "half_sel", half_sel, half);
        check("R6", "card read req", {eng_req, eng_wr}, 2'b10);
        if (poke) begin
            req = 1'b1; host_lba = 21'(lba ^ 5);
            @(negedge clk);
            req = 1'b0;
            check("R9", "card_lba held under req", card_lba, clba);
        end
        for (int i = 0; i < 512; i++) begin
            if ($urandom % 8 == 0) begin
                eng_rvalid = 1'b0;
                @(negedge clk);
            end
            eng_rvalid = 1'b1;
            eng_rdata  = pat(clba, i);
            @(negedge clk);
        end
        eng_rvalid = 1'b0;
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        bad = 0;
        if (!wr) begin
            for (int k = 0; k < 256; k++) begin
                if (!host_rvalid || host_rdata !== pat(clba, half * 256 + k))
                    bad++;
                @(negedge clk);
            end
            check("R6", "read half byte mismatches", bad, 0);
        end else begin
            for (int k = 0; k < 256; k++) begin
                hd[k] = 8'($urandom);
                if ($urandom % 6 == 0) begin
                    host_wvalid = 1'b0;
                    @(negedge clk);
                end
                if (!host_wready) bad++;
                host_wvalid = 1'b1;
                host_wdata  = hd[k];
                @(negedge clk);
            end
            host_wvalid = 1'b0;
            check("R7", "host_wready drops", bad, 0);
            check("R7", "card write req", {eng_req, eng_wr}, 2'b11);
            for (int i = 0; i < 512; i++) begin
                if ($urandom % 8 == 0) begin
                    eng_wready = 1'b0;
                    @(negedge clk);
                end
                eng_wready = 1'b1;
                #1;
                got[i] = eng_wdata;
                @(negedge clk);
            end
            eng_wready = 1'b0;
            eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
            bad = 0;
            for (int i = 0; i < 512; i++) begin
                if ((i >> 8) == half) begin
                    if (got[i] !== hd[i & 255]) bad++;
                end else if (got[i] !== pat(clba, i)) bad++;
            end
            check("R7", "merged sector mismatches", bad, 0);
        end
        check("R8", "done at end", done, 1);
        check("R8", "busy at end", busy, 0);
        check("R8", "no chk_err on success", chk_err, 0);
        @(negedge clk);
        check("R8", "done one cycle", done, 0);
        check("R9", "no restart after done", busy, 0);
    endtask

    initial begin
        int seed = $urandom(32'h5EED1);
        do_reset(4'd0, 4'd0);
        // R3: switch 0 maps straight through to region 0, half 0
        run_txn(1'b0, 32'h01234, 0, 0, 1'b0);
        run_txn(1'b1, 32'h1FFFFF, 0, 0, 1'b0);
        // R1, R2: bit 3 set and later switch change
        do_reset(4'b1011, 4'b0100);
        run_txn(1'b1, 32'h0ABCD, 3, 0, 1'b1);
        run_txn(1'b0, 32'h0ABCD, 3, 1, 1'b0);
        // R5, R4: selector 5 on small card, then on large card
        do_reset(4'd5, 4'd5);
        run_txn(1'b0, 32'h00077, 5, 0, 1'b0);
        run_txn(1'b1, 32'h00077, 5, 0, 1'b0);
        run_txn(1'b0, 32'h00077, 5, 1, 1'b0);
        do_reset(4'd7, 4'd1);
        run_txn(1'b1, 32'h1FFFFF, 7, 1, 1'b0);
        for (int it = 0; it < 10; it++) begin
            logic [3:0] sw = 4'($urandom);
            do_reset(sw, 4'($urandom));
            for (int t = 0; t < 2; t++)
                run_txn(1'($urandom), int'($urandom & 32'h1FFFFF),
                        int'(sw[2:0]), int'($urandom & 1), 1'($urandom));
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule